// File: doc/BRIEF.md
# Bus Cycle Wait-State Generator

This block stretches memory cycles on a PC/AT-style system bus. It decides how many wait states each cycle gets, then holds its ready output low for that many bus clocks, and the CPU cycle logic uses ready to extend the cycle. The wait count depends on three things: which device the cycle targets (on-board ROM, 16-bit option-card memory, or anything else), a CPU speed select, and three strap pins.

The count is fixed at the falling edge of address latch enable. When a read or write strobe first goes active, a down-counter is loaded with that count and ready drops. The slot's zero-wait request ends the wait at once. Releasing the strobe also returns the counter to idle.

There is no data path, so no valid/ready stream handshake is involved. Every pin is a plain level-sampled control signal, and no back-pressure rules apply. All inputs are sampled on the rising clock edge. The reset is synchronous and active high.

Top module: `bus_wait_gen`

## Requirements
- R1: While reset is high, ready is high at each clock after the first reset edge, even with a strobe active. After reset, ready stays high until a strobe goes active.
- R2: A ROM cycle (rom_sel_n low) at the fast speed (speed_slow=0) with strap_rom=0 inserts 2 wait states.
- R3: A ROM cycle at the fast speed with strap_rom=1 inserts 1 wait state.
- R4: A ROM cycle at the slow speed (speed_slow=1) inserts 1 wait state for either value of strap_rom.
- R5: A 16-bit option memory cycle (opt16_sel_n low, rom_sel_n high) at the fast speed inserts 4, 3, 2 or 1 wait states for {strap_hi,strap_lo} = 00, 01, 10 or 11.
- R6: A 16-bit option memory cycle at the slow speed inserts 1 wait state whatever the straps.
- R7: A cycle with both selects high inserts DEFAULT_WAITS (1) wait states. When both selects are low, the ROM rule applies.
- R8: If zws_n is low at any rising edge, ready is high after that edge. A zero-wait request present at the edge where the strobe is first seen gives 0 wait states.
- R9: Selects, speed and straps are captured at the edge where ale is seen falling (ale high at the previous edge, low at this one). Changing them afterwards does not alter the current cycle.
- R10: After the first edge that sees memr_n or memw_n low, ready is low for exactly N clocks, where N is the captured count. A strobe released early returns ready high after the next edge.
- R11: Read (memr_n) and write (memw_n) strobes start the wait in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address latch enable, active high |
| memr_n | input | 1 | Memory read strobe, active low |
| memw_n | input | 1 | Memory write strobe, active low |
| rom_sel_n | input | 1 | On-board ROM chip select, active low |
| opt16_sel_n | input | 1 | 16-bit option memory select, active low |
| zws_n | input | 1 | Zero-wait request from the slot, active low |
| speed_slow | input | 1 | 0 = fast CPU clock, 1 = slow CPU clock |
| strap_rom | input | 1 | ROM wait strap |
| strap_lo | input | 1 | Option memory wait strap, low bit |
| strap_hi | input | 1 | Option memory wait strap, high bit |
| ready | output | 1 | High when the cycle may complete |

## Verification
The assertions assume that reset is applied before the first strobe, so that the edge-detect history holds a defined value. They also assume the strobes and zero-wait request are clean levels at each rising edge. Under those conditions, a run of low ready never exceeds the largest table entry. The stimulus changes inputs only on the falling clock edge. It drops ale at least one clock before asserting a strobe and deliberately scrambles selects and straps after capture. It holds each strobe until ready returns or until a chosen early-release point.

// File: rtl/waitgen_pkg.sv
package waitgen_pkg;
  localparam int ROM_FAST_STRAP0 = 2;
  localparam int ROM_FAST_STRAP1 = 1;
  localparam int SLOW_WAITS      = 1;
  localparam int OPT16_FAST_BASE = 4;
  localparam int MAX_WAITS       = 4;

  typedef enum logic [1:0] {
    DEV_OTHER = 2'd0,
    DEV_ROM   = 2'd1,
    DEV_OPT16 = 2'd2
  } dev_kind_e;

  typedef struct packed {
    logic rom_sel_n;
    logic opt16_sel_n;
    logic speed_slow;
    logic strap_rom;
    logic strap_lo;
    logic strap_hi;
  } cycle_cfg_t;
endpackage

// File: rtl/wait_edge_det.sv
module wait_edge_det #(
  parameter int           W         = 2,
  parameter logic [W-1:0] RISE_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= din;
  end

  // each bit picks a rising or falling detector
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (RISE_MASK[i]) begin : g_rise
      assign edge_hit[i] = din[i] & ~prev_q[i];
    end else begin : g_fall
      assign edge_hit[i] = ~din[i] & prev_q[i];
    end
  end
endmodule

// File: rtl/wait_count_select.sv
module wait_count_select
  import waitgen_pkg::*;
#(
  parameter int CNT_W         = 3,
  parameter int DEFAULT_WAITS = 1
) (
  input  cycle_cfg_t       cfg,
  output logic [CNT_W-1:0] waits
);
  dev_kind_e kind;

  // ROM select wins when both selects are low
  always_comb begin
    if (!cfg.rom_sel_n)        kind = DEV_ROM;
    else if (!cfg.opt16_sel_n) kind = DEV_OPT16;
    else                       kind = DEV_OTHER;
  end

  always_comb begin
    unique case (kind)
      DEV_ROM: begin
        if (cfg.speed_slow)     waits = CNT_W'(SLOW_WAITS);
        else if (cfg.strap_rom) waits = CNT_W'(ROM_FAST_STRAP1);
        else                    waits = CNT_W'(ROM_FAST_STRAP0);
      end
      DEV_OPT16: begin
        if (cfg.speed_slow) waits = CNT_W'(SLOW_WAITS);
        else waits = CNT_W'(OPT16_FAST_BASE) - CNT_W'({cfg.strap_hi, cfg.strap_lo});
      end
      default: waits = CNT_W'(DEFAULT_WAITS);
    endcase
  end
endmodule

// File: rtl/wait_down_counter.sv
module wait_down_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             at_zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (clear)         cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/bus_wait_gen.sv
module bus_wait_gen
  import waitgen_pkg::*;
#(
  parameter int CNT_W         = 3,
  parameter int DEFAULT_WAITS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic ale,
  input  logic memr_n,
  input  logic memw_n,
  input  logic rom_sel_n,
  input  logic opt16_sel_n,
  input  logic zws_n,
  input  logic speed_slow,
  input  logic strap_rom,
  input  logic strap_lo,
  input  logic strap_hi,
  output logic ready
);
  localparam int EDGE_W = 2;
  localparam int IDX_ALE = 0;
  localparam int IDX_STB = 1;
  localparam logic [EDGE_W-1:0] EDGE_RISE = EDGE_W'(1 << IDX_STB);

  logic             strobe_on;
  logic [EDGE_W-1:0] edge_in, edge_hit;
  cycle_cfg_t       cfg_now;
  logic [CNT_W-1:0] waits_now, waits_q, load_val;

  assign strobe_on = ~memr_n | ~memw_n;
  assign edge_in[IDX_ALE] = ale;
  assign edge_in[IDX_STB] = strobe_on;

  assign cfg_now = '{rom_sel_n: rom_sel_n, opt16_sel_n: opt16_sel_n,
                     speed_slow: speed_slow, strap_rom: strap_rom,
                     strap_lo: strap_lo, strap_hi: strap_hi};

  wait_edge_det #(.W(EDGE_W), .RISE_MASK(EDGE_RISE)) u_edges (
    .clk(clk), .rst(rst), .din(edge_in), .edge_hit(edge_hit)
  );

  wait_count_select #(.CNT_W(CNT_W), .DEFAULT_WAITS(DEFAULT_WAITS)) u_sel (
    .cfg(cfg_now), .waits(waits_now)
  );

  always_ff @(posedge clk) begin
    if (rst)                    waits_q <= CNT_W'(DEFAULT_WAITS);
    else if (edge_hit[IDX_ALE]) waits_q <= waits_now;
  end

  // bypass when latch-enable falls on the strobe's first edge
  assign load_val = edge_hit[IDX_ALE] ? waits_now : waits_q;

  wait_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .clear(~zws_n | ~strobe_on),
    .load(edge_hit[IDX_STB]),
    .load_val(load_val),
    .at_zero(ready)
  );
endmodule

// File: rtl/bus_wait_chk.sv
module bus_wait_chk
  import waitgen_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic memr_n,
  input logic memw_n,
  input logic zws_n,
  input logic ready
);
  logic [3:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || ready)      low_run <= '0;
    else if (low_run != 4'hF) low_run <= low_run + 1'b1;
  end

  a_r1_reset_ready: assert property (@(posedge clk) rst |=> ready);

  a_r8_zero_wait: assert property (@(posedge clk) disable iff (rst)
    !zws_n |=> ready);

  a_r10_idle_ready: assert property (@(posedge clk) disable iff (rst)
    (memr_n && memw_n) |=> ready);

  a_r11_fall_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(ready) |-> ($past(!memr_n || !memw_n) && $past(zws_n)));

  a_r5_max_wait: assert property (@(posedge clk) disable iff (rst)
    int'(low_run) <= MAX_WAITS);
endmodule

bind bus_wait_gen bus_wait_chk u_chk (
  .clk(clk), .rst(rst), .memr_n(memr_n), .memw_n(memw_n),
  .zws_n(zws_n), .ready(ready)
);

// File: tb/tb_bus_wait_gen.sv
module tb_bus_wait_gen;
  logic clk = 1'b0;
  logic rst, ale, memr_n, memw_n, rom_sel_n, opt16_sel_n, zws_n;
  logic speed_slow, strap_rom, strap_lo, strap_hi;
  logic ready;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  bus_wait_gen dut (
    .clk(clk), .rst(rst), .ale(ale), .memr_n(memr_n), .memw_n(memw_n),
    .rom_sel_n(rom_sel_n), .opt16_sel_n(opt16_sel_n), .zws_n(zws_n),
    .speed_slow(speed_slow), .strap_rom(strap_rom), .strap_lo(strap_lo),
    .strap_hi(strap_hi), .ready(ready)
  );

  function automatic int exp_waits(logic rn, logic on, logic sl, logic sr,
                                   logic lo, logic hi);
    if (!rn) return sl ? 1 : (sr ? 1 : 2);
    if (!on) return sl ? 1 : 4 - int'({hi, lo});
    return 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // zw_at / rel_at: end the wait after that many low samples (-1 = never)
  task automatic run_cycle(input logic rn, input logic on, input logic sl,
                           input logic sr, input logic lo, input logic hi,
                           input bit wr, input int zw_at, input int rel_at,
                           input string req);
    int n, e, lows;
    @(negedge clk);
    ale = 1'b1; rom_sel_n = rn; opt16_sel_n = on; speed_slow = sl;
    strap_rom = sr; strap_lo = lo; strap_hi = hi;
    @(negedge clk);
    ale = 1'b0;
    @(negedge clk);
    // R9: scramble the capture inputs after latch-enable has fallen
    {rom_sel_n, opt16_sel_n, speed_slow, strap_rom, strap_lo, strap_hi} = 6'($urandom);
    if (wr) memw_n = 1'b0; else memr_n = 1'b0;
    if (zw_at == 0) zws_n = 1'b0;
    n = exp_waits(rn, on, sl, sr, lo, hi);
    e = n;
    if (zw_at >= 0 && zw_at < e) e = zw_at;
    if (rel_at > 0 && rel_at < e) e = rel_at;
    lows = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (ready) break;
      lows++;
      if (lows == zw_at) zws_n = 1'b0;
      if (lows == rel_at) begin memr_n = 1'b1; memw_n = 1'b1; end
    end
    check(lows == e, req, lows, e);
    memr_n = 1'b1; memw_n = 1'b1; zws_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R10 idle after strobe release", int'(ready), 1);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst = 1'b1; ale = 1'b0; memr_n = 1'b0; memw_n = 1'b1; zws_n = 1'b1;
    rom_sel_n = 1'b0; opt16_sel_n = 1'b1; speed_slow = 1'b0;
    strap_rom = 1'b0; strap_lo = 1'b0; strap_hi = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R1 ready high in reset with strobe", int'(ready), 1);
    memr_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(ready == 1'b1, "R1 ready high after reset", int'(ready), 1);

    run_cycle(0, 1, 0, 0, 0, 0, 0, -1, -1, "R2 rom fast strap0");
    run_cycle(0, 1, 0, 1, 0, 0, 1, -1, -1, "R3 rom fast strap1");
    run_cycle(0, 1, 1, 0, 0, 0, 0, -1, -1, "R4 rom slow strap0");
    run_cycle(0, 1, 1, 1, 1, 1, 1, -1, -1, "R4 rom slow strap1");
    run_cycle(1, 0, 0, 0, 0, 0, 0, -1, -1, "R5 opt16 fast 00");
    run_cycle(1, 0, 0, 0, 1, 0, 1, -1, -1, "R5 opt16 fast 01");
    run_cycle(1, 0, 0, 0, 0, 1, 0, -1, -1, "R5 opt16 fast 10");
    run_cycle(1, 0, 0, 0, 1, 1, 1, -1, -1, "R5 opt16 fast 11");
    run_cycle(1, 0, 1, 0, 0, 0, 0, -1, -1, "R6 opt16 slow");
    run_cycle(1, 1, 0, 0, 0, 0, 0, -1, -1, "R7 default cycle");
    run_cycle(0, 0, 0, 0, 0, 0, 1, -1, -1, "R7 rom priority");
    run_cycle(1, 0, 0, 0, 0, 0, 0, 0, -1, "R8 zero-wait at strobe start");
    run_cycle(1, 0, 0, 0, 0, 0, 1, 2, -1, "R8 zero-wait mid cycle");
    run_cycle(0, 1, 0, 0, 0, 0, 0, -1, 1, "R10 early strobe release");
    run_cycle(1, 0, 0, 0, 0, 0, 1, -1, -1, "R11 write strobe count");

    for (int k = 0; k < 400; k++) begin
      logic [5:0] r;
      int zw, rl;
      r = 6'($urandom);
      zw = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
      rl = ($urandom % 5 == 0) ? 1 + int'($urandom % 3) : -1;
      run_cycle(r[0], r[1], r[2], r[3], r[4], r[5], bit'($urandom % 2), zw, rl,
                "R9 R10 random cycle");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule